// File: doc/BRIEF.md
# Two-Rate Three-Color Policer

This block meters a stream of frames against two token buckets and assigns each frame a colour. The committed bucket is filled at the committed rate and holds at most the committed burst. The peak bucket is filled at the peak rate and holds at most the peak burst. Each frame is announced by a one-cycle strobe together with its length in octets and an incoming colour. One cycle later the block returns the colour and a drop flag.

The colour result can be acted on in three configurable ways. Yellow frames can be dropped instead of passed. Red frames can be passed with a red mark instead of dropped. The meter can also run colour-aware, so that a colour assigned upstream can only be kept or made worse.

Rates are given in kbit/s and bursts in octets. Token levels are kept in millibits, so one tick at a rate of R kbit/s adds exactly R millibits. The tick is expected once per microsecond. Producing that tick from the system clock, and selecting one meter out of many, are done outside this block.

Top module: `trtcm_policer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, result_valid_o is 0, and both buckets count as full: committed level = cbs_i*8000 and peak level = pbs_i*8000 millibits.
- R2: Colours are encoded 0 = green, 1 = yellow, 2 = red. In colour-blind mode the cost of a frame is frame_len_i*8000 millibits. The frame is red if the peak level is below the cost, yellow if it is not red and the committed level is below the cost, and green otherwise.
- R3: On a cycle with tick_i high, cir_i millibits are added to the committed level and pir_i millibits to the peak level. Each level is then clamped to its burst times 8000. A burst lowered below the current level clamps that level from the next cycle on.
- R4: A green frame takes its cost from both buckets. A yellow frame takes it from the peak bucket only. A red frame takes no tokens. This holds whether or not the frame is dropped.
- R5: A strobe on frame_valid_i produces result_valid_o, color_o and drop_o on the next cycle. With no strobe, result_valid_o is 0 on the next cycle.
- R6: drop_o is 1 for a yellow result when drop_yellow_i is 1, and 0 for a yellow result otherwise. A green result never has drop_o set.
- R7: drop_o is 1 for a red result when mark_red_i is 0. When mark_red_i is 1, a red result is passed with drop_o 0 and color_o still 2.
- R8: When color_aware_i is 1, an incoming red frame (color_in_i = 2) is red and takes no tokens. An incoming yellow frame (color_in_i = 1) is red if the peak level is below the cost and yellow otherwise, and never green. An incoming green frame (color_in_i = 0) is treated as in R2.
- R9: When tick_i and frame_valid_i are high in the same cycle, the colour is decided on the levels held before that tick. The debit and the refill are then both applied, and the clamp of R3 follows.
- R10: When color_aware_i is 1, color_in_i = 3 is treated as red. When color_aware_i is 0, color_in_i has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cir_i | input | RATE_W | Committed rate, kbit/s |
| pir_i | input | RATE_W | Peak rate, kbit/s |
| cbs_i | input | BURST_W | Committed burst, octets |
| pbs_i | input | BURST_W | Peak burst, octets |
| drop_yellow_i | input | 1 | Drop yellow results |
| mark_red_i | input | 1 | Pass red results marked instead of dropping them |
| color_aware_i | input | 1 | Take color_in_i into account |
| tick_i | input | 1 | Refill tick, nominally 1 us |
| frame_valid_i | input | 1 | Frame strobe |
| frame_len_i | input | LEN_W | Frame length, octets |
| color_in_i | input | 2 | Incoming colour |
| result_valid_o | output | 1 | Result strobe |
| color_o | output | 2 | Resulting colour |
| drop_o | output | 1 | Drop the frame |

## Verification
The risky coincidence is a refill tick landing on the same cycle as a frame strobe. The decision must use the level from before the tick, while the debit, the refill and the clamp all land in a single update. The bench drives ticks at random with frame strobes on most cycles, and runs with buckets near empty so that the extra tokens from a tick would change the colour if they were counted too early. A behavioural model of the levels, kept as integers, predicts colour and drop for every strobe and is compared on every clock.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;
  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  localparam int unsigned MB_PER_OCTET = 8000;  // millibits per octet
  localparam int unsigned SCALE_W      = 13;    // bits needed for the factor 8000
endpackage

// File: rtl/trtcm_bucket.sv
module trtcm_bucket #(
  parameter int unsigned RATE_W  = 20,
  parameter int unsigned BURST_W = 16,
  parameter int unsigned TOK_W   = BURST_W + trtcm_pkg::SCALE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic               tick_i,
  input  logic               debit_i,
  input  logic [TOK_W-1:0]   cost_i,
  output logic [TOK_W-1:0]   level_o,
  output logic               enough_o
);
  localparam logic [TOK_W-1:0] SCALE = TOK_W'(trtcm_pkg::MB_PER_OCTET);

  logic [TOK_W-1:0] tok_q, cap, after_debit;
  logic [TOK_W:0]   sum;

  assign cap      = {{(TOK_W-BURST_W){1'b0}}, burst_i} * SCALE;
  // all-ones at reset reads as full for any burst
  assign level_o  = (tok_q > cap) ? cap : tok_q;
  assign enough_o = (level_o >= cost_i);

  always_comb begin
    after_debit = debit_i ? (level_o - cost_i) : level_o;
    sum = {1'b0, after_debit} + (tick_i ? {{(TOK_W+1-RATE_W){1'b0}}, rate_i} : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '1;
    else         tok_q <= (sum > {1'b0, cap}) ? cap : sum[TOK_W-1:0];
  end
endmodule

// File: rtl/trtcm_decide.sv
module trtcm_decide
  import trtcm_pkg::*;
(
  input  logic       valid_i,
  input  logic       aware_i,
  input  logic [1:0] color_in_i,
  input  logic       c_enough_i,
  input  logic       p_enough_i,
  output color_e     color_o,
  output logic       debit_c_o,
  output logic       debit_p_o
);
  color_e blind;

  always_comb begin
    if (!p_enough_i)      blind = COL_RED;
    else if (!c_enough_i) blind = COL_YELLOW;
    else                  blind = COL_GREEN;

    color_o = blind;
    if (aware_i) begin
      unique case (color_in_i)
        2'd0:    color_o = blind;
        2'd1:    color_o = p_enough_i ? COL_YELLOW : COL_RED;
        default: color_o = COL_RED;
      endcase
    end

    debit_c_o = valid_i && (color_o == COL_GREEN);
    debit_p_o = valid_i && (color_o != COL_RED);
  end
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
  import trtcm_pkg::*;
#(
  parameter int unsigned RATE_W  = 20,
  parameter int unsigned BURST_W = 16,
  parameter int unsigned LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATE_W-1:0]  cir_i,
  input  logic [RATE_W-1:0]  pir_i,
  input  logic [BURST_W-1:0] cbs_i,
  input  logic [BURST_W-1:0] pbs_i,
  input  logic               drop_yellow_i,
  input  logic               mark_red_i,
  input  logic               color_aware_i,
  input  logic               tick_i,
  input  logic               frame_valid_i,
  input  logic [LEN_W-1:0]   frame_len_i,
  input  logic [1:0]         color_in_i,
  output logic               result_valid_o,
  output logic [1:0]         color_o,
  output logic               drop_o
);
  localparam int unsigned TOK_W = BURST_W + SCALE_W;
  localparam int unsigned NB    = 2;  // 0 committed, 1 peak
  localparam logic [TOK_W-1:0] SCALE = TOK_W'(MB_PER_OCTET);

  logic [TOK_W-1:0]   cost;
  logic [TOK_W-1:0]   lvl   [NB];
  logic [NB-1:0]      enough, debit;
  logic [RATE_W-1:0]  rate  [NB];
  logic [BURST_W-1:0] burst [NB];
  logic [TOK_W-1:0]   lvl_c, lvl_p;
  color_e             col_d;
  logic               drop_d;

  assign cost     = {{(TOK_W-LEN_W){1'b0}}, frame_len_i} * SCALE;
  assign rate[0]  = cir_i;
  assign rate[1]  = pir_i;
  assign burst[0] = cbs_i;
  assign burst[1] = pbs_i;
  assign lvl_c    = lvl[0];
  assign lvl_p    = lvl[1];

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    trtcm_bucket #(.RATE_W(RATE_W), .BURST_W(BURST_W), .TOK_W(TOK_W)) u_bkt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rate_i   (rate[b]),
      .burst_i  (burst[b]),
      .tick_i   (tick_i),
      .debit_i  (debit[b]),
      .cost_i   (cost),
      .level_o  (lvl[b]),
      .enough_o (enough[b])
    );
  end

  trtcm_decide u_decide (
    .valid_i    (frame_valid_i),
    .aware_i    (color_aware_i),
    .color_in_i (color_in_i),
    .c_enough_i (enough[0]),
    .p_enough_i (enough[1]),
    .color_o    (col_d),
    .debit_c_o  (debit[0]),
    .debit_p_o  (debit[1])
  );

  always_comb begin
    unique case (col_d)
      COL_RED:    drop_d = !mark_red_i;
      COL_YELLOW: drop_d = drop_yellow_i;
      default:    drop_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      color_o        <= COL_GREEN;
      drop_o         <= 1'b0;
    end else begin
      result_valid_o <= frame_valid_i;
      if (frame_valid_i) begin
        color_o <= col_d;
        drop_o  <= drop_d;
      end
    end
  end
endmodule

// File: rtl/trtcm_policer_chk.sv
module trtcm_policer_chk #(
  parameter int unsigned BURST_W = 16,
  parameter int unsigned TOK_W   = 29
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_valid_i,
  input logic               tick_i,
  input logic               color_aware_i,
  input logic [1:0]         color_in_i,
  input logic               mark_red_i,
  input logic               drop_yellow_i,
  input logic [BURST_W-1:0] cbs_i,
  input logic [BURST_W-1:0] pbs_i,
  input logic               result_valid_o,
  input logic [1:0]         color_o,
  input logic               drop_o,
  input logic [TOK_W-1:0]   lvl_c,
  input logic [TOK_W-1:0]   lvl_p
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> result_valid_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !result_valid_o); // R5
  AST_GREEN_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && color_o == 2'd0) |-> !drop_o); // R6
  AST_YELLOW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && drop_yellow_i) |=> (color_o != 2'd1 || drop_o)); // R6
  AST_RED_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> (color_o != 2'd2 || drop_o == !$past(mark_red_i))); // R7
  AST_AWARE_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && color_aware_i && color_in_i[1]) |=> color_o == 2'd2); // R8
  AST_AWARE_NO_UPGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && color_aware_i && color_in_i == 2'd1) |=> color_o != 2'd0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_valid_i && !tick_i) |=> ($stable(cbs_i) && $stable(pbs_i)) |->
      (lvl_c == $past(lvl_c) && lvl_p == $past(lvl_p))); // R3
endmodule

bind trtcm_policer trtcm_policer_chk #(.BURST_W(BURST_W), .TOK_W(TOK_W)) u_chk (.*);

// File: tb/trtcm_policer_tb.sv
module trtcm_policer_tb;
  localparam int RATE_W = 20, BURST_W = 16, LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RATE_W-1:0] cir = '0, pir = '0;
  logic [BURST_W-1:0] cbs = '0, pbs = '0;
  logic dy = 1'b0, mr = 1'b0, aw = 1'b0, tick = 1'b0, fv = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [1:0] cin = '0;
  logic rv, drop;
  logic [1:0] col;

  int checks = 0, fails = 0;
  longint mc, mp;
  bit ex_v = 0, ex_d = 0, ex_aware = 0;
  int ex_c = 0;

  always #10 clk = ~clk;  // 50 MHz

  trtcm_policer #(.RATE_W(RATE_W), .BURST_W(BURST_W), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cir_i(cir), .pir_i(pir), .cbs_i(cbs), .pbs_i(pbs),
    .drop_yellow_i(dy), .mark_red_i(mr), .color_aware_i(aw), .tick_i(tick),
    .frame_valid_i(fv), .frame_len_i(len), .color_in_i(cin),
    .result_valid_o(rv), .color_o(col), .drop_o(drop));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic longint lmin(longint a, longint b);
    return a < b ? a : b;
  endfunction

  // behavioural reference: levels in millibits, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 64'(cbs) * 8000; mp = 64'(pbs) * 8000; ex_v = 0;  // R1: full
    end else begin
      longint lc, lp, cost;
      int c;
      lc = lmin(mc, 64'(cbs) * 8000);
      lp = lmin(mp, 64'(pbs) * 8000);
      cost = 64'(len) * 8000;
      c = (lp < cost) ? 2 : (lc < cost) ? 1 : 0;            // R2
      if (aw) begin                                          // R8, R10
        if (cin == 2'd1) c = (lp < cost) ? 2 : 1;
        else if (cin != 2'd0) c = 2;
      end
      ex_v = fv;                                             // R5
      if (fv) begin
        ex_c = c; ex_aware = aw;
        ex_d = (c == 2) ? !mr : (c == 1) ? dy : 1'b0;        // R6, R7
        if (c == 0) lc -= cost;                              // R4
        if (c != 2) lp -= cost;
      end
      if (tick) begin lc += cir; lp += pir; end              // R3, R9: after decision
      mc = lmin(lc, 64'(cbs) * 8000);
      mp = lmin(lp, 64'(pbs) * 8000);
    end
  end

  // compare on the falling edge
  always @(negedge clk) if (rst_n) begin
    chk(rv == ex_v, "R5 valid", rv, ex_v);
    if (ex_v) begin
      chk(col == 2'(ex_c), ex_aware ? "R8/R10 colour (R2 rule, R4 R9 levels)" : "R2 colour (R3 R4 R9 levels)", col, ex_c);
      chk(drop == ex_d, ex_c == 2 ? "R7 drop" : "R6 drop", drop, ex_d);
    end
  end

  task automatic run(input int n, input int tick_pct, input int fv_pct, input int lmax);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      tick = ($urandom_range(99) < tick_pct);
      fv   = ($urandom_range(99) < fv_pct);
      len  = LEN_W'($urandom_range(lmax, 1));
      cin  = 2'($urandom_range(3));
    end
  endtask

  initial begin
    int wd;
    cir = 20'd8000; pir = 20'd16000; cbs = 16'd200; pbs = 16'd400;
    repeat (3) @(negedge clk);
    // R1: during reset nothing is reported
    chk(rv == 1'b0, "R1 reset valid", rv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rv == 1'b0, "R1 first cycle valid", rv, 0);
    // R1/R2: a full-committed-burst frame is green straight after reset
    #1; fv = 1; len = 16'd200;
    @(negedge clk); #1; fv = 0;
    chk(col == 2'd0 && !drop, "R1 full at reset", col, 0);
    // R2/R4: committed now empty, peak has 200 octets left -> yellow then red
    fv = 1; len = 16'd150;
    @(negedge clk); #1;
    chk(col == 2'd1, "R4 yellow after green debit", col, 1);
    fv = 1; len = 16'd100;
    @(negedge clk); #1; fv = 0;
    chk(col == 2'd2 && drop, "R2 red when peak short", col, 2);
    // R3/R9: near-empty buckets, ticks coinciding with frames
    run(2000, 40, 70, 12);
    // R6/R7 actions
    dy = 1; mr = 1; run(1500, 30, 60, 40);
    dy = 0; mr = 0;
    // R8/R10: colour-aware with random incoming colours
    aw = 1; run(2000, 30, 70, 30);
    // R3 clamp: shrink bursts mid-run, then big refill
    cbs = 16'd50; pbs = 16'd60; cir = 20'd900000; pir = 20'd1000000;
    aw = 0; dy = 1; run(1500, 50, 50, 70);
    // R10: blind mode ignores incoming colour (colour drawn at random above)
    cbs = 16'd3000; pbs = 16'd6000; cir = 20'd510000; pir = 20'd720000;
    run(1500, 20, 80, 1500);
    @(negedge clk); #1; fv = 0; tick = 0;
    repeat (3) @(negedge clk);
    wd = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule